// File: doc/BRIEF.md
# LIN Frame Transmit Sequencer

This block sits between a host that writes bytes one at a time and a byte-wide serializer that drives a LIN bus. The meaning of each accepted host byte depends on where it falls in the frame. The first byte is the frame identifier. The second is the data length. The third holds the option bits. Receive frames take a fourth byte, a response timeout, which transmit frames leave out. Every byte after that is payload, until the programmed length is used up.

The block sends the identifier to the serializer, with protected-identifier parity inserted when parity is enabled. It then forwards each payload byte. After the payload it can append a CRC-8 byte and an inverted end-around-carry checksum byte without any further host writes.

A bit error reported by the bus monitor aborts the frame and blocks all host writes until the host clears the error flag. A flush input throws away a partly written frame. Two sticky flags, frame complete and bit error, drive a single interrupt line through per-flag enables.

Top module: `lin_tx_sequencer`

## Requirements
- R1: `tx_ready` is high only when no byte is pending at the serializer, no bit-error lockout is active, and the sequencer is waiting for a host byte. A `host_wr` pulse while `tx_ready` is low is ignored.
- R2: Accepted bytes are read in this order: identifier, length, options. Options bit 0 set to 1 marks a transmit frame, and the next byte is then the first data byte. With bit 0 at 0 (receive), one more byte (timeout) is taken, nothing further is sent, and the byte after it is a new identifier.
- R3: In a transmit frame, exactly `length` data bytes are forwarded to the serializer in write order, each held stable on `ser_data` with `ser_valid` high until `ser_ready` completes the handshake.
- R4: The identifier byte is sent unchanged when `parity_en` is 0. When it is 1, bits 5..0 are kept, bit 6 = ID0^ID1^ID2^ID4 and bit 7 = ~(ID1^ID3^ID4^ID5).
- R5: With options bit 2 set, a CRC-8 byte follows the data. The CRC uses polynomial 0x1D, initial value 0x00, is computed MSB first over the data bytes only, and has no final inversion.
- R6: With options bit 1 set, a checksum byte follows the data (and follows the CRC if both are set). The checksum is the bitwise inverse of the 8-bit sum of the data bytes, with each carry added back in.
- R7: `flag_done` rises one cycle after the handshake of the last byte of a transmit frame. For a zero-length frame with no CRC or checksum, it rises one cycle after the options byte is accepted. A receive frame never sets it.
- R8: `bit_err` while `ser_valid` is high drops `ser_valid`, sets `flag_biterr` and returns the sequencer to expecting an identifier. `tx_ready` stays low until `flag_biterr` is cleared.
- R9: A `flush` pulse drops any pending byte and returns the sequencer to expecting an identifier, discarding the partial frame.
- R10: Flags are cleared by writing 1 to `irq_clr` (bit 0 clears done, bit 1 clears bit error). They stay set otherwise. `irq` is high exactly when a flag and its `irq_en` bit are both 1.
- R11: After reset, `tx_ready` is 1, and `ser_valid`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | 8 | Host byte |
| parity_en | input | 1 | Insert identifier parity bits |
| flush | input | 1 | Discard partial frame |
| tx_ready | output | 1 | Host may write |
| ser_valid | output | 1 | Byte offered to serializer |
| ser_data | output | 8 | Byte to serializer |
| ser_ready | input | 1 | Serializer takes the byte |
| bit_err | input | 1 | Bus monitor bit error |
| irq_en | input | 2 | Enables: bit 0 done, bit 1 bit error |
| irq_clr | input | 2 | Write-1-to-clear for the flags |
| flag_done | output | 1 | Frame complete flag |
| flag_biterr | output | 1 | Bit error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host only pulses `host_wr` after it has seen `tx_ready`, except in tests that deliberately probe an ignored write. They also assume that `bit_err` is raised only while a byte is on the bus, and that `ser_ready` may be held low for any number of cycles. The stimulus follows these rules. A serializer model in the bench raises `ser_ready` for one cycle per offered byte, unless a stall variable holds it off. Bit errors are injected only while that stall keeps a byte pending, and flush is pulsed only between host writes.

// File: rtl/lin_tx_pkg.sv
// Shared types and pure functions for the LIN transmit sequencer.
// Assumes byte-wide host and serializer paths.
package lin_tx_pkg;
    localparam int BYTE_W  = 8;
    localparam int OPT_DIR = 0;   // 1 = transmit frame
    localparam int OPT_SUM = 1;   // append checksum
    localparam int OPT_CRC = 2;   // append CRC-8

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_ID, ST_LEN, ST_OPT, ST_TMO, ST_DATA, ST_CRC, ST_SUM
    } seq_state_e;

    // Protected identifier: two parity bits over the six identifier bits.
    function automatic byte_t protect_id(input byte_t id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id[5:0]};
    endfunction

    // One byte of MSB-first CRC-8 update.
    function automatic byte_t crc_step(input byte_t crc, input byte_t d, input byte_t poly);
        byte_t c;
        c = crc ^ d;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[BYTE_W-1] ? byte_t'((c << 1) ^ poly) : byte_t'(c << 1);
        end
        return c;
    endfunction

    // Add a byte with end-around carry.
    function automatic byte_t sum_step(input byte_t acc, input byte_t d);
        logic [BYTE_W:0] t;
        t = {1'b0, acc} + {1'b0, d};
        return byte_t'(t[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, t[BYTE_W]});
    endfunction
endpackage

// File: rtl/lin_tx_check.sv
// Running CRC and checksum over the data bytes of one frame.
// Assumes clr comes with the identifier byte and upd once per data byte.
module lin_tx_check
    import lin_tx_pkg::*;
#(
    parameter byte_t CRC_POLY = 8'h1D,
    parameter byte_t CRC_INIT = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  upd,
    input  byte_t din,
    output byte_t crc_q,
    output byte_t sum_q
);
    // Accumulate both check values; clear on a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= CRC_INIT;
            sum_q <= '0;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, din, CRC_POLY);
            sum_q <= sum_step(sum_q, din);
        end
    end
endmodule

// File: rtl/lin_tx_irq.sv
// Sticky write-1-to-clear flags with per-flag enables feeding one interrupt.
// Assumes set pulses are single cycle; set wins over a same-cycle clear.
module lin_tx_irq #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flag,
    output logic             irq
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // Hold flag g until software writes 1 to its clear bit.
        always_ff @(posedge clk) begin
            if (!rst_n) flag[g] <= 1'b0;
            else        flag[g] <= set[g] | (flag[g] & ~clr[g]);
        end

        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] && !set[g] |=> !flag[g]);                  // R10
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flag[g] && !clr[g] |=> flag[g]);                  // R10
    end

    // Combine enabled flags.
    always_comb irq = |(flag & en);
endmodule

// File: rtl/lin_tx_fsm.sv
// Byte-position sequencer: decodes identifier, length, options and
// timeout bytes, forwards data, then emits CRC and checksum on its own.
// Assumes the serializer holds ser_ready low until it takes a byte, and
// bit_err is meaningful only while a byte is pending.
module lin_tx_fsm
    import lin_tx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  host_wr,
    input  byte_t host_data,
    input  logic  parity_en,
    input  logic  flush,
    input  logic  bit_err,
    input  logic  lockout,
    input  logic  ser_ready,
    input  byte_t crc_val,
    input  byte_t sum_val,
    output logic  tx_ready,
    output logic  ser_valid,
    output byte_t ser_data,
    output logic  acc_clr,
    output logic  acc_upd,
    output logic  frame_done,
    output logic  abort
);
    seq_state_e       state_q;
    logic [LEN_W-1:0] left_q;
    logic             crc_en_q, sum_en_q;
    logic             busy_q, last_q;
    byte_t            byte_q;
    logic             wr_ok, hs, host_state;

    // Pick the state after payload from the tail options.
    function automatic seq_state_e tail_state(input logic c, input logic s);
        return c ? ST_CRC : (s ? ST_SUM : ST_ID);
    endfunction

    // Decode readiness and handshake events.
    always_comb begin
        host_state = (state_q == ST_ID) || (state_q == ST_LEN) || (state_q == ST_OPT)
                  || (state_q == ST_TMO) || (state_q == ST_DATA);
        tx_ready   = !busy_q && !lockout && host_state;
        wr_ok      = host_wr && tx_ready;
        hs         = busy_q && ser_ready;
        abort      = bit_err && busy_q;
        acc_clr    = flush || (wr_ok && state_q == ST_ID);
        acc_upd    = wr_ok && state_q == ST_DATA;
        frame_done = (hs && last_q)
                  || (wr_ok && state_q == ST_OPT && host_data[OPT_DIR] && left_q == '0
                      && !host_data[OPT_CRC] && !host_data[OPT_SUM]);
        ser_valid  = busy_q;
        ser_data   = byte_q;
    end

    // Main sequencer: byte position decoding, payload and tail emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ID;
            left_q   <= '0;
            crc_en_q <= 1'b0;
            sum_en_q <= 1'b0;
            busy_q   <= 1'b0;
            last_q   <= 1'b0;
            byte_q   <= '0;
        end else if (flush || abort) begin
            state_q <= ST_ID;
            busy_q  <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            if (hs) begin
                busy_q <= 1'b0;
                last_q <= 1'b0;
            end
            if (wr_ok) begin
                unique case (state_q)
                    ST_ID: begin
                        byte_q  <= parity_en ? protect_id(host_data) : host_data;
                        busy_q  <= 1'b1;
                        state_q <= ST_LEN;
                    end
                    ST_LEN: begin
                        left_q  <= LEN_W'(host_data);
                        state_q <= ST_OPT;
                    end
                    ST_OPT: begin
                        crc_en_q <= host_data[OPT_CRC];
                        sum_en_q <= host_data[OPT_SUM];
                        if (!host_data[OPT_DIR])   state_q <= ST_TMO;
                        else if (left_q == '0)     state_q <= tail_state(host_data[OPT_CRC], host_data[OPT_SUM]);
                        else                       state_q <= ST_DATA;
                    end
                    ST_TMO: state_q <= ST_ID;
                    ST_DATA: begin
                        byte_q <= host_data;
                        busy_q <= 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == LEN_W'(1)) begin
                            state_q <= tail_state(crc_en_q, sum_en_q);
                            last_q  <= !crc_en_q && !sum_en_q;
                        end
                    end
                    default: ;
                endcase
            end else if (!busy_q) begin
                if (state_q == ST_CRC) begin
                    byte_q  <= crc_val;
                    busy_q  <= 1'b1;
                    state_q <= sum_en_q ? ST_SUM : ST_ID;
                    last_q  <= !sum_en_q;
                end else if (state_q == ST_SUM) begin
                    byte_q  <= ~sum_val;
                    busy_q  <= 1'b1;
                    state_q <= ST_ID;
                    last_q  <= 1'b1;
                end
            end
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid && !ser_ready && !bit_err && !flush |=> ser_valid && $stable(ser_data)); // R3
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ser_valid);                                                  // R9
    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err && ser_valid |=> !ser_valid);                                   // R8
endmodule

// File: rtl/lin_tx_sequencer.sv
// Top of the LIN frame transmit sequencer: joins the byte sequencer,
// the check-value accumulator and the interrupt flags.
// Assumes a byte handshake serializer and a host that polls tx_ready.
module lin_tx_sequencer
    import lin_tx_pkg::*;
#(
    parameter int    LEN_W    = 8,
    parameter byte_t CRC_POLY = 8'h1D,
    parameter byte_t CRC_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    input  logic       parity_en,
    input  logic       flush,
    output logic       tx_ready,
    output logic       ser_valid,
    output logic [7:0] ser_data,
    input  logic       ser_ready,
    input  logic       bit_err,
    input  logic [1:0] irq_en,
    input  logic [1:0] irq_clr,
    output logic       flag_done,
    output logic       flag_biterr,
    output logic       irq
);
    localparam int NFLAG = 2;

    byte_t            crc_val, sum_val;
    logic             acc_clr, acc_upd, frame_done, abort;
    logic [NFLAG-1:0] flags;

    lin_tx_fsm #(.LEN_W(LEN_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .parity_en(parity_en), .flush(flush), .bit_err(bit_err),
        .lockout(flags[1]), .ser_ready(ser_ready), .crc_val(crc_val),
        .sum_val(sum_val), .tx_ready(tx_ready), .ser_valid(ser_valid),
        .ser_data(ser_data), .acc_clr(acc_clr), .acc_upd(acc_upd),
        .frame_done(frame_done), .abort(abort)
    );

    lin_tx_check #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) chk_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .upd(acc_upd),
        .din(host_data), .crc_q(crc_val), .sum_q(sum_val)
    );

    lin_tx_irq #(.NFLAG(NFLAG)) irq_i (
        .clk(clk), .rst_n(rst_n), .set({abort, frame_done}), .clr(irq_clr),
        .en(irq_en), .flag(flags), .irq(irq)
    );

    // Expose individual flags.
    always_comb begin
        flag_done   = flags[0];
        flag_biterr = flags[1];
    end

    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_biterr |-> !tx_ready);                                   // R8
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> $past(ser_ready || host_wr));            // R7
endmodule

// File: tb/lin_tx_sequencer_tb.sv
module lin_tx_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {id, parity, len, opt, data0..data3, expected header}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h3C, 8'h01, 8'd2, 8'h03, 32'h5593_0000, 8'h3C},
        {8'h00, 8'h01, 8'd4, 8'h07, 32'h0102_0304, 8'h80},
        {8'h01, 8'h01, 8'd1, 8'h05, 32'hFF00_0000, 8'hC1},
        {8'hA5, 8'h00, 8'd3, 8'h01, 32'h1020_3000, 8'hA5},
        {8'h12, 8'h01, 8'd0, 8'h07, 32'h0000_0000, 8'h92},
        {8'h12, 8'h01, 8'd2, 8'h03, 32'hFFFF_0000, 8'h92}
    };

    logic clk = 0, rst_n = 0, host_wr = 0, parity_en = 0, flush = 0;
    logic ser_ready = 0, bit_err = 0;
    logic [7:0] host_data = 0;
    logic [1:0] irq_en = 0, irq_clr = 0;
    logic tx_ready, ser_valid, flag_done, flag_biterr, irq;
    logic [7:0] ser_data;

    int errors = 0, checks = 0, cycles = 0;
    bit stall = 0, reported = 0;
    logic [7:0] cap [16];
    int cap_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_tx_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .parity_en(parity_en), .flush(flush), .tx_ready(tx_ready),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
        .bit_err(bit_err), .irq_en(irq_en), .irq_clr(irq_clr),
        .flag_done(flag_done), .flag_biterr(flag_biterr), .irq(irq)
    );

    // Serializer model: takes one offered byte per handshake unless stalled.
    always @(negedge clk) begin
        if (ser_ready) ser_ready = 0;
        else if (ser_valid && !stall) begin
            ser_ready = 1;
            if (cap_n < 16) cap[cap_n] = ser_data;
            cap_n++;
        end
    end

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] b);
        int w = 0;
        @(negedge clk);
        while (!tx_ready && w < 500) begin @(negedge clk); w++; end
        host_wr = 1; host_data = b;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic raw_write(input logic [7:0] b);
        @(negedge clk); host_wr = 1; host_data = b;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 200 && !flag_done; i++) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = 0;
    endtask

    function automatic logic [7:0] crc_ref(input logic [7:0] d [4], input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[7] ^ d[k][b];
                c = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h1D;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] sum_ref(input logic [7:0] d [4], input int n);
        int s = 0;
        for (int k = 0; k < n; k++) begin
            s = s + d[k];
            if (s > 255) s = s - 255;
        end
        return ~8'(s);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(tx_ready == 1, "R11 tx_ready", tx_ready, 1);
        chk(ser_valid == 0, "R11 ser_valid", ser_valid, 0);
        chk({flag_done, flag_biterr, irq} == 0, "R11 flags", {flag_done, flag_biterr, irq}, 0);

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] id, len, opt, hdr;
            logic [7:0] d [4];
            int n;
            id = VEC[v][71:64]; parity_en = VEC[v][56]; len = VEC[v][55:48];
            opt = VEC[v][47:40]; hdr = VEC[v][7:0];
            for (int i = 0; i < 4; i++) d[i] = VEC[v][39-8*i -: 8];
            cap_n = 0;
            hwrite(id); hwrite(len); hwrite(opt);
            for (int i = 0; i < len; i++) hwrite(d[i]);
            wait_done();
            chk(flag_done == 1, "R7 done", flag_done, 1);
            n = 1 + len + opt[2] + opt[1];
            chk(cap_n == n, "R3 byte count", cap_n, n);
            chk(cap[0] == hdr, "R4 header", cap[0], hdr);
            for (int i = 0; i < len; i++)
                chk(cap[1+i] == d[i], "R3 data", cap[1+i], d[i]);
            if (opt[2]) chk(cap[1+len] == crc_ref(d, len), "R5 crc", cap[1+len], crc_ref(d, len));
            if (opt[1]) chk(cap[n-1] == sum_ref(d, len), "R6 checksum", cap[n-1], sum_ref(d, len));
            clear(2'b01);
        end

        // R2 receive descriptor takes a timeout byte and sends only the header
        parity_en = 1; cap_n = 0;
        hwrite(8'h3C); hwrite(8'd2); hwrite(8'h02); hwrite(8'h10);
        repeat (4) @(negedge clk);
        chk(cap_n == 1, "R2 rx header only", cap_n, 1);
        chk(flag_done == 0, "R7 rx no done", flag_done, 0);
        hwrite(8'h01); hwrite(8'd1); hwrite(8'h01); hwrite(8'h5A);
        wait_done();
        chk(cap[1] == 8'hC1, "R2 next byte is header", cap[1], 8'hC1);
        chk(cap[2] == 8'h5A && cap_n == 3, "R2 tx data", cap[2], 8'h5A);
        clear(2'b01);

        // R1 write ignored while a byte is pending
        cap_n = 0; stall = 1;
        hwrite(8'h3C);
        @(negedge clk);
        chk(tx_ready == 0 && ser_valid == 1, "R1 busy not ready", tx_ready, 0);
        raw_write(8'h77);
        stall = 0;
        hwrite(8'd1); hwrite(8'h01); hwrite(8'h44);
        wait_done();
        chk(cap_n == 2 && cap[1] == 8'h44, "R1 ignored write", cap[1], 8'h44);
        clear(2'b01);

        // R8 bit error abort and lockout
        cap_n = 0; stall = 1; irq_en = 2'b10;
        hwrite(8'h3C);
        @(negedge clk); bit_err = 1;
        @(negedge clk); bit_err = 0;
        chk(flag_biterr == 1, "R8 flag", flag_biterr, 1);
        chk(ser_valid == 0, "R8 dropped", ser_valid, 0);
        chk(tx_ready == 0, "R8 lockout", tx_ready, 0);
        chk(irq == 1, "R10 irq bit error", irq, 1);
        raw_write(8'h3C);
        stall = 0;
        repeat (4) @(negedge clk);
        chk(cap_n == 0 && ser_valid == 0, "R8 write refused", cap_n, 0);
        clear(2'b10);
        chk(flag_biterr == 0 && irq == 0 && tx_ready == 1, "R10 clear bit error",
            {flag_biterr, irq, tx_ready}, 3'b001);
        hwrite(8'h01); hwrite(8'd0); hwrite(8'h01);
        chk(cap_n == 1 && cap[0] == 8'hC1, "R8 new header", cap[0], 8'hC1);
        chk(flag_done == 1, "R7 zero length done", flag_done, 1);
        clear(2'b01);

        // R9 flush discards partial frame; R10 masking
        irq_en = 0; cap_n = 0;
        hwrite(8'h3C); hwrite(8'd3);
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        hwrite(8'h00); hwrite(8'd0); hwrite(8'h01);
        chk(cap_n == 2 && cap[1] == 8'h80, "R9 header after flush", cap[1], 8'h80);
        chk(flag_done == 1 && irq == 0, "R10 masked", irq, 0);
        irq_en = 2'b01;
        @(negedge clk);
        chk(irq == 1, "R10 enabled", irq, 1);
        repeat (3) @(negedge clk);
        chk(flag_done == 1, "R10 sticky", flag_done, 1);
        clear(2'b01);
        chk(flag_done == 0 && irq == 0, "R10 w1c", {flag_done, irq}, 0);

        report();
    end
endmodule